// File: doc/BRIEF.md
# Refresh Mode Decoder for an Asynchronous DRAM

This block sits inside an asynchronous DRAM die, between the active-low control pins and the row decoder. A fast reference clock samples the row strobe, column strobe, write strobe, chip select, output enable and address pins. The block decides what each falling edge of the row strobe means. If the column strobe is high at that edge, the address pins name the row to open. If the column strobe is already low, the edge starts a self-addressed refresh: the address pins are not used, and the row comes from an internal counter that then steps to the next row.

A row that opens and closes with no column strobe falling in between counts as a row-only refresh. A row that sees a column strobe counts as an ordinary access. The block also decides when the data pins are driven. A read keeps them driven for as long as the column strobe stays low, including the case where the row strobe goes high and falls again for a hidden refresh. Output enable only masks the data pins, and chip select high hides every pin event. The storage array itself is not part of the block.

Top module: `dram_refresh_decoder`

## Requirements
- R1: After reset, `row_open`, `refresh_pulse`, `refresh_cbr` and `dout_en` are 0 and `row_sel` is 0.
- R2: A falling row strobe while the column strobe is high (1) and chip select is low opens a row. `row_open` goes to 1 and `row_sel` takes the value on `addr`.
- R3: While the row strobe stays low, `row_open` stays 1 and `row_sel` holds its value, even when `addr` changes.
- R4: When the row strobe rises on a row that saw no falling column strobe, `refresh_pulse` is 1 for one cycle, `refresh_cbr` is 0, and `row_sel` still shows the refreshed row. A row that did see a falling column strobe gives no pulse when it closes.
- R5: A falling row strobe while the column strobe is already low is a self-addressed refresh. `addr` is ignored, `row_sel` takes the internal counter value, `row_open` goes to 1, and `refresh_pulse` is 1 for one cycle with `refresh_cbr` set to 1.
- R6: The internal row counter starts at 0 and steps by one after each self-addressed refresh. It wraps from NUM_ROWS-1 back to 0. Nothing else moves it.
- R7: When chip select is high, edges on the row and column strobes are ignored: no row opens, no refresh is counted and the counter does not move. `dout_en` is also 0 while chip select is high.
- R8: A falling column strobe on an open row with the write strobe high (a read) sets `dout_en` to 1. A rising column strobe clears it. A falling column strobe with the write strobe low (a write) leaves it at 0.
- R9: Hidden refresh: when the row strobe rises while the column strobe stays low after a read, `dout_en` stays 1. When the row strobe then falls again, a self-addressed refresh runs and `dout_en` is still 1.
- R10: Output enable high holds `dout_en` at 0. Row opening, refresh and the counter still work as normal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low (high means read) |
| cs_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Multiplexed address pins |
| row_sel | output | ADDR_W | Row handed to the row decoder |
| row_open | output | 1 | Row is currently open |
| refresh_pulse | output | 1 | One-cycle marker, one for each refresh |
| refresh_cbr | output | 1 | Kind of refresh at the pulse: 1 self-addressed, 0 row-only |
| dout_en | output | 1 | Data pins driven |

## Verification
Every pin first passes two synchronizer flops. One more register compares the new sample with the previous one, and one state register sits behind that. So a pin change made at a falling clock edge shows on `row_open`, `row_sel`, `refresh_pulse` and `dout_en` after the third rising edge. The bench changes pins only at falling edges and waits four cycles before it reads any level, so every level check lands after the result is due and before the next stimulus. Row openings and refresh pulses are short or event-like, so the driver queues the row and refresh kind it expects for each one. A monitor then compares them at each falling edge, whenever a `row_open` rise or a `refresh_pulse` appears. Any event that arrives with nothing queued is a failure.

// File: rtl/rfd_pkg.sv
package rfd_pkg;

    typedef enum logic [1:0] {
        KIND_IDLE = 2'd0,
        KIND_PEND = 2'd1,
        KIND_ACC  = 2'd2,
        KIND_CBR  = 2'd3
    } row_kind_e;

    localparam int CTRL_W = 5;

    typedef struct packed {
        logic ras_n;
        logic cas_n;
        logic we_n;
        logic cs_n;
        logic oe_n;
    } ctrl_t;

    localparam ctrl_t CTRL_IDLE = '{ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1,
                                    cs_n: 1'b1, oe_n: 1'b1};

endpackage

// File: rtl/rfd_sync.sv
module rfd_sync #(
    parameter int             W       = 8,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] stage_d [STAGES];
    logic [W-1:0] stage_q [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_comb stage_d[i] = din;
        end else begin : g_next
            always_comb stage_d[i] = stage_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
        end else begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= stage_d[i];
        end
    end

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/rfd_row_counter.sv
module rfd_row_counter #(
    parameter int NUM_ROWS = 4096,
    localparam int CNT_W = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(NUM_ROWS - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (advance) begin
            cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        advance |=> cnt_q == (($past(cnt_q) == LAST) ? '0 : $past(cnt_q) + 1'b1)); // R6

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> $stable(cnt_q)); // R6

endmodule

// File: rtl/rfd_classifier.sv
module rfd_classifier
    import rfd_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_n_s,
    input  logic              cas_n_s,
    input  logic              cs_n_s,
    input  logic [ADDR_W-1:0] addr_s,
    input  logic [ADDR_W-1:0] cnt_row,
    output logic              cnt_adv,
    output logic              cas_fall,
    output logic              cas_rise,
    output logic              ras_rise,
    output logic [ADDR_W-1:0] row_o,
    output logic              row_open_o,
    output logic              pulse_o,
    output logic              cbr_o
);

    typedef struct packed {
        row_kind_e         kind;
        logic [ADDR_W-1:0] row;
        logic              pulse;
        logic              cbr;
        logic              p_ras;
        logic              p_cas;
    } cls_t;

    cls_t q, n;
    logic cs_act, ras_fall;

    assign cs_act   = !cs_n_s;
    assign ras_fall = cs_act &&  q.p_ras && !ras_n_s;
    assign ras_rise = cs_act && !q.p_ras &&  ras_n_s;
    assign cas_fall = cs_act &&  q.p_cas && !cas_n_s;
    assign cas_rise = cs_act && !q.p_cas &&  cas_n_s;

    always_comb begin
        n       = q;
        n.pulse = 1'b0;
        n.p_ras = ras_n_s;
        n.p_cas = cas_n_s;
        cnt_adv = 1'b0;
        if (ras_fall && q.kind == KIND_IDLE) begin
            if (!cas_n_s) begin
                n.kind  = KIND_CBR;
                n.row   = cnt_row;
                n.pulse = 1'b1;
                n.cbr   = 1'b1;
                cnt_adv = 1'b1;
            end else begin
                n.kind = KIND_PEND;
                n.row  = addr_s;
            end
        end else if (ras_rise && q.kind != KIND_IDLE) begin
            if (q.kind == KIND_PEND) begin
                n.pulse = 1'b1;
                n.cbr   = 1'b0;
            end
            n.kind = KIND_IDLE;
        end else if (cas_fall && q.kind == KIND_PEND) begin
            n.kind = KIND_ACC;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.kind  <= KIND_IDLE;
            q.row   <= '0;
            q.pulse <= 1'b0;
            q.cbr   <= 1'b0;
            q.p_ras <= 1'b1;
            q.p_cas <= 1'b1;
        end else begin
            q <= n;
        end
    end

    assign row_o      = q.row;
    assign row_open_o = (q.kind != KIND_IDLE);
    assign pulse_o    = q.pulse;
    assign cbr_o      = q.cbr;

    AST_ROW_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (row_open_o && $past(row_open_o)) |-> $stable(row_o)); // R3

    AST_CBR_ROW_FROM_CNT: assert property (@(posedge clk) disable iff (!rst_n)
        (q.pulse && q.cbr) |-> (q.row == $past(cnt_row))); // R5

    AST_ROR_AT_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
        (q.pulse && !q.cbr) |-> (q.kind == KIND_IDLE)); // R4

    AST_DESELECT_NO_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n_s && !row_open_o) |=> !row_open_o); // R7

endmodule

// File: rtl/rfd_out_ctrl.sv
module rfd_out_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic cas_fall,
    input  logic cas_rise,
    input  logic ras_rise,
    input  logic row_open,
    input  logic we_n_s,
    input  logic oe_n_s,
    input  logic cs_n_s,
    output logic dout_en
);

    typedef struct packed {
        logic valid;
        logic drive;
    } oc_t;

    oc_t q, n;

    always_comb begin
        n = q;
        if (cas_rise) begin
            n.valid = 1'b0;
        end else if (cas_fall && row_open) begin
            n.valid = we_n_s;
        end
        n.drive = n.valid && !oe_n_s && !cs_n_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign dout_en = q.drive;

    AST_OE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(oe_n_s) |-> !dout_en); // R10

    AST_HIDDEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (q.valid && ras_rise && !cas_rise) |=> q.valid); // R9

    AST_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (cas_fall && row_open && !we_n_s) |=> !dout_en); // R8

endmodule

// File: rtl/dram_refresh_decoder.sv
module dram_refresh_decoder
    import rfd_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int NUM_ROWS    = 4096,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic              cs_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    output logic [ADDR_W-1:0] row_sel,
    output logic              row_open,
    output logic              refresh_pulse,
    output logic              refresh_cbr,
    output logic              dout_en
);

    localparam int CNT_W  = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1;
    localparam int PIN_W  = CTRL_W + ADDR_W;
    localparam logic [PIN_W-1:0] PIN_RST = {CTRL_IDLE, {ADDR_W{1'b0}}};

    ctrl_t             ctrl_raw, ctrl_s;
    logic [ADDR_W-1:0] addr_s;
    logic [PIN_W-1:0]  pins_s;
    logic [CNT_W-1:0]  cnt;
    logic [ADDR_W-1:0] cnt_row;
    logic              cnt_adv, cas_fall, cas_rise, ras_rise;

    assign ctrl_raw = '{ras_n: ras_n, cas_n: cas_n, we_n: we_n,
                        cs_n: cs_n, oe_n: oe_n};

    rfd_sync #(.W(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({ctrl_raw, addr}),
        .dout (pins_s)
    );

    assign ctrl_s = ctrl_t'(pins_s[PIN_W-1:ADDR_W]);
    assign addr_s = pins_s[ADDR_W-1:0];

    rfd_row_counter #(.NUM_ROWS(NUM_ROWS)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .advance(cnt_adv),
        .cnt    (cnt)
    );

    assign cnt_row = ADDR_W'(cnt);

    rfd_classifier #(.ADDR_W(ADDR_W)) u_cls (
        .clk       (clk),
        .rst_n     (rst_n),
        .ras_n_s   (ctrl_s.ras_n),
        .cas_n_s   (ctrl_s.cas_n),
        .cs_n_s    (ctrl_s.cs_n),
        .addr_s    (addr_s),
        .cnt_row   (cnt_row),
        .cnt_adv   (cnt_adv),
        .cas_fall  (cas_fall),
        .cas_rise  (cas_rise),
        .ras_rise  (ras_rise),
        .row_o     (row_sel),
        .row_open_o(row_open),
        .pulse_o   (refresh_pulse),
        .cbr_o     (refresh_cbr)
    );

    rfd_out_ctrl u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .cas_fall(cas_fall),
        .cas_rise(cas_rise),
        .ras_rise(ras_rise),
        .row_open(row_open),
        .we_n_s  (ctrl_s.we_n),
        .oe_n_s  (ctrl_s.oe_n),
        .cs_n_s  (ctrl_s.cs_n),
        .dout_en (dout_en)
    );

endmodule

// File: tb/sim_dram_refresh_decoder.sv
`timescale 1ns/1ps
module sim_dram_refresh_decoder;

    localparam int AW = 4;
    localparam int NR = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, cs_n = 1'b0, oe_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [AW-1:0] row_sel;
    logic row_open, refresh_pulse, refresh_cbr, dout_en;

    int total = 0;
    int bad   = 0;
    int exp_cnt = 0;
    bit done = 1'b0;

    typedef struct { logic cbr; logic [AW-1:0] row; } ref_t;
    logic [AW-1:0] open_q [$];
    ref_t          ref_q  [$];

    always #2.5 clk = ~clk;

    dram_refresh_decoder #(.ADDR_W(AW), .NUM_ROWS(NR)) u0 (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .cs_n(cs_n), .oe_n(oe_n), .addr(addr), .row_sel(row_sel),
        .row_open(row_open), .refresh_pulse(refresh_pulse),
        .refresh_cbr(refresh_cbr), .dout_en(dout_en)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic open_row(input logic [AW-1:0] a);
        open_q.push_back(a);
        addr  = a;
        ras_n = 1'b0;
        settle();
    endtask

    task automatic close_ror(input logic [AW-1:0] a);
        ref_t r;
        r.cbr = 1'b0; r.row = a;
        ref_q.push_back(r);
        ras_n = 1'b1;
        settle();
    endtask

    task automatic cbr_fall();
        ref_t r;
        r.cbr = 1'b1; r.row = AW'(exp_cnt);
        open_q.push_back(AW'(exp_cnt));
        ref_q.push_back(r);
        exp_cnt = (exp_cnt == NR - 1) ? 0 : exp_cnt + 1;
        ras_n = 1'b0;
        settle();
    endtask

    // Scoreboard monitor
    logic prev_open = 1'b0;
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (row_open && !prev_open) begin
                if (open_q.size() == 0) begin
                    check(1'b0, "R2/R5 unexpected row open", int'(row_sel), -1);
                end else begin
                    logic [AW-1:0] e;
                    e = open_q.pop_front();
                    check(row_sel == e, "R2/R5 opened row", int'(row_sel), int'(e));
                end
            end
            if (refresh_pulse) begin
                if (ref_q.size() == 0) begin
                    check(1'b0, "R4/R5/R7 unexpected refresh", int'(refresh_cbr), -1);
                end else begin
                    ref_t e;
                    e = ref_q.pop_front();
                    check(refresh_cbr == e.cbr, "R4/R5 refresh kind", int'(refresh_cbr), int'(e.cbr));
                    check(row_sel == e.row, "R4/R5 refresh row", int'(row_sel), int'(e.row));
                end
            end
            prev_open <= row_open;
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(row_open == 1'b0, "R1 row_open", int'(row_open), 0);
        check(dout_en == 1'b0, "R1 dout_en", int'(dout_en), 0);
        check(row_sel == '0, "R1 row_sel", int'(row_sel), 0);
        check(refresh_pulse == 1'b0, "R1 refresh_pulse", int'(refresh_pulse), 0);
        rst_n = 1'b1;
        settle();

        // R2 open, R3 hold, R4 row-only refresh
        open_row(4'd5);
        check(row_open == 1'b1, "R2 row_open", int'(row_open), 1);
        addr = 4'd9;
        settle();
        check(row_sel == 4'd5, "R3 row held", int'(row_sel), 5);
        check(row_open == 1'b1, "R3 still open", int'(row_open), 1);
        close_ror(4'd5);
        check(row_open == 1'b0, "R4 closed", int'(row_open), 0);

        // R8 read access, no refresh at close (R4)
        open_row(4'd3);
        we_n = 1'b1; cas_n = 1'b0;
        settle();
        check(dout_en == 1'b1, "R8 read drives", int'(dout_en), 1);
        cas_n = 1'b1;
        settle();
        check(dout_en == 1'b0, "R8 cas rise clears", int'(dout_en), 0);
        ras_n = 1'b1;
        settle();

        // R8 write access
        open_row(4'd6);
        we_n = 1'b0; cas_n = 1'b0;
        settle();
        check(dout_en == 1'b0, "R8 write no drive", int'(dout_en), 0);
        cas_n = 1'b1; ras_n = 1'b1;
        settle();
        we_n = 1'b1;
        settle();

        // R5 self-addressed refresh ignores addr
        cas_n = 1'b0; addr = 4'd12;
        settle();
        check(dout_en == 1'b0, "R8 cas without row", int'(dout_en), 0);
        cbr_fall();
        check(row_sel == 4'd0, "R5 counter row", int'(row_sel), 0);
        check(row_open == 1'b1, "R5 row open", int'(row_open), 1);
        ras_n = 1'b1; settle();
        cas_n = 1'b1; settle();

        // R9 hidden refresh
        open_row(4'd2);
        cas_n = 1'b0;
        settle();
        check(dout_en == 1'b1, "R9 read before hidden", int'(dout_en), 1);
        ras_n = 1'b1;
        settle();
        check(dout_en == 1'b1, "R9 held over ras rise", int'(dout_en), 1);
        check(row_open == 1'b0, "R9 row closed", int'(row_open), 0);
        cbr_fall();
        check(dout_en == 1'b1, "R9 held during refresh", int'(dout_en), 1);
        check(row_sel == 4'd1, "R9 refresh row", int'(row_sel), 1);
        ras_n = 1'b1; settle();
        cas_n = 1'b1; settle();
        check(dout_en == 1'b0, "R8 cleared after hidden", int'(dout_en), 0);

        // R10 output enable
        oe_n = 1'b1;
        open_row(4'd4);
        cas_n = 1'b0;
        settle();
        check(dout_en == 1'b0, "R10 oe blocks", int'(dout_en), 0);
        oe_n = 1'b0;
        settle();
        check(dout_en == 1'b1, "R10 oe released", int'(dout_en), 1);
        oe_n = 1'b1;
        ras_n = 1'b1; settle();
        cbr_fall();
        check(dout_en == 1'b0, "R10 blocked in refresh", int'(dout_en), 0);
        ras_n = 1'b1; settle();
        cas_n = 1'b1; oe_n = 1'b0; settle();

        // R7 chip select high ignores strobes
        cs_n = 1'b1;
        addr = 4'd7; ras_n = 1'b0;
        settle();
        check(row_open == 1'b0, "R7 no open when deselected", int'(row_open), 0);
        ras_n = 1'b1; settle();
        cas_n = 1'b0; settle();
        ras_n = 1'b0; settle();
        check(row_open == 1'b0, "R7 no refresh when deselected", int'(row_open), 0);
        check(dout_en == 1'b0, "R7 no drive when deselected", int'(dout_en), 0);
        ras_n = 1'b1; cas_n = 1'b1; settle();
        cs_n = 1'b0; settle();

        // R6 counter steps and wraps (3..7 then 0, 1)
        for (int k = 0; k < 7; k++) begin
            cas_n = 1'b0; settle();
            cbr_fall();
            ras_n = 1'b1; settle();
            cas_n = 1'b1; settle();
        end
        check(exp_cnt == 2, "R6 bench count", exp_cnt, 2);

        settle();
        check(open_q.size() == 0, "R2/R5 open events missing", open_q.size(), 0);
        check(ref_q.size() == 0, "R4/R5 refresh events missing", ref_q.size(), 0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule